// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is a 16-bit up-counting timer whose count drives one PWM output pin through two compare points. The first compare point moves the pin to its active level. The second compare point returns the pin to its idle level and ends the period, so the counter goes back to zero on the next count clock. Software reaches the timer through a single-cycle register port. Through that port it sets both compare values, reads and loads the counter, picks the count clock source and its division, and shapes the output. The output controls are an idle level, an optional inversion and an output enable.

Each match raises a sticky flag whether or not its interrupt is enabled. A per-flag enable gates the flags onto one interrupt request line. When the compare values are double-buffered, new compare values take effect only at a period boundary, so a running waveform never sees a half-updated period. Fine mode halves the compare values' count positions. It uses the lowest compare bit to push an output edge half a count clock later, which doubles the placement resolution of the output edges.

Top module: `pwm16_timer`

## Requirements
- R1: After reset every register reads 0x0000, `pwm_out` is 0 and `irq` is 0.
- R2: Registers are addressed by word: 0 compare-A, 1 compare-B, 2 counter, 3 control, 4 divider code (bits 3:0), 5 interrupt enable (bits 1:0), 6 flags (bits 1:0). Address 7 and all unused bits read 0. Compare, counter, divider and enable registers read back what was written.
- R3: Control bit 1 is a clear strobe. Writing it as 1 sets the counter to 0 and returns the output to its idle level. Writing it as 0 has no effect, and the bit always reads 0.
- R4: While control bit 0 (run) is 1, each count clock adds 1 to the counter. When the counter holds the compare-B position, the next count clock sets it to 0, so a period is compare-B + 1 count clocks. While run is 0 the counter holds its value.
- R5: With control bit 3 at 0, a count clock occurs every 2^k cycles of `clk`, where k is the divider code 0x0 to 0xE. Code 0xF divides like 0xE (1/16384).
- R6: With control bit 3 at 1, a count clock occurs on each rising edge of `ext_clk`, seen through a two-stage synchronizer.
- R7: Control bit 8 is the idle level and bit 4 inverts the pin. A count clock that brings the counter to compare-A makes the pin active (the opposite of the idle level). One that brings it to compare-B makes the pin idle again, and B wins when both match. With control bit 2 at 0 the pin is 0.
- R8: With control bit 5 at 1, compare writes go to shadow copies that become active when the counter wraps at the compare-B position. Reads return the shadow copy. With bit 5 at 0, writes take effect at once.
- R9: With control bit 6 at 1, the counter matches at compare>>1. A compare value with bit 0 set moves its output edge half a count clock later (2^(k-1) cycles of `clk` for k ≥ 1).
- R10: Flag bit 0 (A) and bit 1 (B) are set on each matching count clock, whether or not interrupts are enabled. Writing 1 to a flag bit clears it, and a same-cycle match wins over the clear.
- R11: `irq` is 1 exactly when some flag bit and the enable bit at the same position are both 1.
- R12: A counter write loads the value. A counter loaded above the compare-B position counts up to 0xFFFF and then rolls over to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch, on every cycle, the rules that connect one cycle to the next:
- the counter returns to zero after a compare-B wrap;
- the counter holds still while stopped;
- a counter write or a clear lands;
- buffered compare values hold until a wrap;
- a match always leaves its flag set, and a write-one clears it;
- reserved control bits read as zero.

The waveform properties only show up over a whole period, so they are left to the bench scenarios. These are the active time and period as a function of the divider code, the external source, fine-mode half-cycle placement, idle level and inversion, and the timing of a buffered compare update. The bench measures them from pin edges and compares them against closed-form values.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CMPA = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMPB = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DIV  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd6;

  localparam int CB_RUN  = 0;
  localparam int CB_CLR  = 1;
  localparam int CB_OEN  = 2;
  localparam int CB_EXT  = 3;
  localparam int CB_INV  = 4;
  localparam int CB_BUF  = 5;
  localparam int CB_FINE = 6;
  localparam int CB_IDLE = 8;

  typedef struct packed {
    logic idle_lvl;
    logic fine;
    logic buf_en;
    logic invert;
    logic ext_sel;
    logic out_en;
    logic run;
  } tmr_ctrl_t;

endpackage

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
  parameter int MAX_SHIFT = 14,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ext_sel,
  input  logic              ext_clk,
  input  logic [CODE_W-1:0] code,
  output logic              cnt_tick,
  output logic              half_tick
);

  localparam int PW = MAX_SHIFT;
  localparam logic [CODE_W-1:0] SHIFT_CAP = CODE_W'(MAX_SHIFT);

  logic [PW-1:0]     pre_q, pre_n;
  logic [2:0]        sync_q, sync_n;
  logic [CODE_W-1:0] shift;
  logic [PW:0]       span;
  logic [PW-1:0]     lim;
  logic              int_tick, int_half, ext_rise, ext_fall;

  // codes above the cap divide like the cap
  always_comb begin
    shift    = (code > SHIFT_CAP) ? SHIFT_CAP : code;
    span     = ({{PW{1'b0}}, 1'b1} << shift) - {{PW{1'b0}}, 1'b1};
    lim      = span[PW-1:0];
    int_tick = ((pre_q & lim) == lim);
    int_half = (shift == '0) ? int_tick : ((pre_q & lim) == (lim >> 1));
    ext_rise = sync_q[1] & ~sync_q[2];
    ext_fall = ~sync_q[1] & sync_q[2];
    pre_n    = run ? (pre_q + 1'b1) : '0;
    sync_n   = {sync_q[1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_n;
      sync_q <= sync_n;
    end
  end

  assign cnt_tick  = run & (ext_sel ? ext_rise : int_tick);
  assign half_tick = run & (ext_sel ? ext_fall : int_half);

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         fine,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         match_a,
  output logic         match_b,
  output logic         wrap
);

  logic [W-1:0] cnt_q, cnt_n, step, pos_a, pos_b;
  logic         cnt_en, at_end, quiet;

  always_comb begin
    pos_a   = fine ? (cmp_a >> 1) : cmp_a;
    pos_b   = fine ? (cmp_b >> 1) : cmp_b;
    at_end  = (cnt_q == pos_b);
    step    = at_end ? '0 : (cnt_q + 1'b1);
    quiet   = ~clr & ~load;
    cnt_en  = clr | load | tick;
    cnt_n   = clr ? '0 : (load ? load_val : step);
    match_a = tick & quiet & (step == pos_a);
    match_b = tick & quiet & (step == pos_b);
    wrap    = tick & quiet & at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic fine,
  input  logic lsb_a,
  input  logic lsb_b,
  input  logic match_a,
  input  logic match_b,
  input  logic half_tick,
  input  logic clr,
  input  logic out_en,
  input  logic invert,
  input  logic idle_lvl,
  output logic pin
);

  logic phase_q, phase_n;
  logic pend_a_q, pend_a_n, pend_b_q, pend_b_n;
  logic late_a, late_b, go_act, go_idle, fire_a, fire_b, level;

  always_comb begin
    late_a  = fine & lsb_a;
    late_b  = fine & lsb_b;
    fire_a  = half_tick & pend_a_q;
    fire_b  = half_tick & pend_b_q;
    go_act  = (match_a & ~late_a) | fire_a;
    go_idle = (match_b & ~late_b) | fire_b;

    pend_a_n = pend_a_q;
    if (fire_a)           pend_a_n = 1'b0;
    if (match_a & late_a) pend_a_n = 1'b1;
    pend_b_n = pend_b_q;
    if (fire_b)           pend_b_n = 1'b0;
    if (match_b & late_b) pend_b_n = 1'b1;

    phase_n = phase_q;
    if (go_act)  phase_n = 1'b1;
    if (go_idle) phase_n = 1'b0;

    if (clr) begin
      phase_n  = 1'b0;
      pend_a_n = 1'b0;
      pend_b_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      pend_a_q <= pend_a_n;
      pend_b_q <= pend_b_n;
    end
  end

  assign level = phase_q ? ~idle_lvl : idle_lvl;
  assign pin   = out_en & (level ^ invert);

endmodule

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int CODE_W = 4,
  parameter int NIRQ   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      cnt_val,
  input  logic              match_a,
  input  logic              match_b,
  input  logic              wrap,
  output tmr_ctrl_t         ctrl,
  output logic [CODE_W-1:0] div_code,
  output logic [W-1:0]      cmp_a,
  output logic [W-1:0]      cmp_b,
  output logic [NIRQ-1:0]   flags,
  output logic              cnt_wr,
  output logic              clr,
  output logic              irq
);

  tmr_ctrl_t         ctrl_q, ctrl_n;
  logic [CODE_W-1:0] div_q, div_n;
  logic [NIRQ-1:0]   ien_q, ien_n, flag_q, flag_n, wipe;
  logic [W-1:0]      sha_q, sha_n, shb_q, shb_n, acta_q, acta_n, actb_q, actb_n;

  always_comb begin
    ctrl_n = ctrl_q;
    div_n  = div_q;
    ien_n  = ien_q;
    sha_n  = sha_q;
    shb_n  = shb_q;
    acta_n = acta_q;
    actb_n = actb_q;
    wipe   = '0;

    if (wrap && ctrl_q.buf_en) begin
      acta_n = sha_q;
      actb_n = shb_q;
    end

    if (wr) begin
      unique case (addr)
        ADR_CMPA: begin
          sha_n = wdata;
          if (!ctrl_q.buf_en) acta_n = wdata;
        end
        ADR_CMPB: begin
          shb_n = wdata;
          if (!ctrl_q.buf_en) actb_n = wdata;
        end
        ADR_CTRL: begin
          ctrl_n.idle_lvl = wdata[CB_IDLE];
          ctrl_n.fine     = wdata[CB_FINE];
          ctrl_n.buf_en   = wdata[CB_BUF];
          ctrl_n.invert   = wdata[CB_INV];
          ctrl_n.ext_sel  = wdata[CB_EXT];
          ctrl_n.out_en   = wdata[CB_OEN];
          ctrl_n.run      = wdata[CB_RUN];
        end
        ADR_DIV:  div_n = wdata[CODE_W-1:0];
        ADR_IEN:  ien_n = wdata[NIRQ-1:0];
        ADR_FLAG: wipe  = wdata[NIRQ-1:0];
        default: ;
      endcase
    end

    // a match in the same cycle overrides the write-one clear
    flag_n = (flag_q & ~wipe) | {match_b, match_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
      sha_q  <= '0;
      shb_q  <= '0;
      acta_q <= '0;
      actb_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      div_q  <= div_n;
      ien_q  <= ien_n;
      flag_q <= flag_n;
      sha_q  <= sha_n;
      shb_q  <= shb_n;
      acta_q <= acta_n;
      actb_q <= actb_n;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_CMPA: rdata = sha_q;
      ADR_CMPB: rdata = shb_q;
      ADR_CNT:  rdata = cnt_val;
      ADR_CTRL: rdata = {{(W-9){1'b0}}, ctrl_q.idle_lvl, 1'b0, ctrl_q.fine,
                         ctrl_q.buf_en, ctrl_q.invert, ctrl_q.ext_sel,
                         ctrl_q.out_en, 1'b0, ctrl_q.run};
      ADR_DIV:  rdata = {{(W-CODE_W){1'b0}}, div_q};
      ADR_IEN:  rdata = {{(W-NIRQ){1'b0}}, ien_q};
      ADR_FLAG: rdata = {{(W-NIRQ){1'b0}}, flag_q};
      default:  rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign div_code = div_q;
  assign cmp_a    = acta_q;
  assign cmp_b    = actb_q;
  assign flags    = flag_q;
  assign cnt_wr   = wr && (addr == ADR_CNT);
  assign clr      = wr && (addr == ADR_CTRL) && wdata[CB_CLR];
  assign irq      = |(flag_q & ien_q);

endmodule

// File: rtl/pwm16_timer.sv
module pwm16_timer
  import pwm_tmr_pkg::*;
#(
  parameter int W         = 16,
  parameter int CODE_W    = 4,
  parameter int MAX_SHIFT = 14,
  parameter int NIRQ      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              pwm_out,
  output logic              irq
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  tmr_ctrl_t         ctrl_q;
  logic [CODE_W-1:0] div_code;
  logic [W-1:0]      cmp_a_act, cmp_b_act, cnt_val;
  logic [NIRQ-1:0]   flags;
  logic              cnt_wr, clr, cnt_tick, half_tick, match_a, match_b, wrap;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  pwm_tmr_regs #(.W(W), .CODE_W(CODE_W), .NIRQ(NIRQ)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cnt_val(cnt_val), .match_a(match_a), .match_b(match_b),
    .wrap(wrap), .ctrl(ctrl_q), .div_code(div_code), .cmp_a(cmp_a_act),
    .cmp_b(cmp_b_act), .flags(flags), .cnt_wr(cnt_wr), .clr(clr), .irq(irq)
  );

  pwm_tmr_prescale #(.MAX_SHIFT(MAX_SHIFT), .CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst_n(rst_n_i), .run(ctrl_q.run), .ext_sel(ctrl_q.ext_sel),
    .ext_clk(ext_clk), .code(div_code), .cnt_tick(cnt_tick), .half_tick(half_tick)
  );

  pwm_tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .tick(cnt_tick), .fine(ctrl_q.fine),
    .cmp_a(cmp_a_act), .cmp_b(cmp_b_act), .clr(clr), .load(cnt_wr),
    .load_val(reg_wdata), .cnt(cnt_val), .match_a(match_a), .match_b(match_b),
    .wrap(wrap)
  );

  pwm_tmr_wave u_wave (
    .clk(clk), .rst_n(rst_n_i), .fine(ctrl_q.fine), .lsb_a(cmp_a_act[0]),
    .lsb_b(cmp_b_act[0]), .match_a(match_a), .match_b(match_b),
    .half_tick(half_tick), .clr(clr), .out_en(ctrl_q.out_en),
    .invert(ctrl_q.invert), .idle_lvl(ctrl_q.idle_lvl), .pin(pwm_out)
  );

endmodule

// File: rtl/pwm16_timer_chk.sv
module pwm16_timer_chk
  import pwm_tmr_pkg::*;
#(
  parameter int W    = 16,
  parameter int NIRQ = 2
) (
  input logic              clk,
  input logic              rst_n,
  input tmr_ctrl_t         ctrl,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      cmp_b,
  input logic              tick,
  input logic              clr,
  input logic              cnt_wr,
  input logic              match_a,
  input logic              wrap,
  input logic [NIRQ-1:0]   flags,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      reg_rdata,
  input logic              pwm_out
);

  logic [W-1:0] end_pos;
  assign end_pos = ctrl.fine ? (cmp_b >> 1) : cmp_b;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_CTRL) |-> (reg_rdata[W-1:9] == '0 && !reg_rdata[7] && !reg_rdata[CB_CLR]));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && pwm_out == (ctrl.out_en & (ctrl.idle_lvl ^ ctrl.invert))));

  assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !cnt_wr && !clr) |=> $stable(cnt));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == end_pos && !clr && !cnt_wr) |=> (cnt == '0));

  assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.buf_en && !wrap) |=> $stable(cmp_b));

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> flags[0]);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_FLAG && reg_wdata[0] && !match_a) |=> !flags[0]);

  assert_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !clr) |=> (cnt == $past(reg_wdata)));

endmodule

bind pwm16_timer pwm16_timer_chk #(.W(W), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .ctrl(ctrl_q), .cnt(cnt_val), .cmp_b(cmp_b_act),
  .tick(cnt_tick), .clr(clr), .cnt_wr(cnt_wr), .match_a(match_a), .wrap(wrap),
  .flags(flags), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .pwm_out(pwm_out)
);

// File: tb/pwm16_timer_bench.sv
module pwm16_timer_bench;

  localparam logic [2:0] A_CMPA = 3'd0, A_CMPB = 3'd1, A_CNT = 3'd2, A_CTRL = 3'd3,
                         A_DIV = 3'd4, A_IEN = 3'd5, A_FLAG = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n, ext_clk, ext_run, reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  wire  [15:0] reg_rdata;
  wire         pwm_out, irq;
  logic [1:0]  ext_div;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pwm16_timer u_pwm16_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  // external clock: 8 system clocks per period
  always @(negedge clk) begin
    if (!ext_run) begin
      ext_clk <= 1'b0;
      ext_div <= 2'd0;
    end else begin
      ext_div <= ext_div + 2'd1;
      if (ext_div == 2'd3) ext_clk <= ~ext_clk;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_lvl(input logic v, output int t);
    logic prev;
    prev = pwm_out;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (pwm_out == v && prev != v) break;
      prev = pwm_out;
    end
    t = cyc;
  endtask

  task automatic meas(input logic idle, output int act, output int per);
    int t0, t1, t2;
    wait_lvl(~idle, t0);
    wait_lvl(idle, t1);
    wait_lvl(~idle, t2);
    act = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic cfg(input logic [15:0] c, input logic [3:0] k,
                     input logic [15:0] a, input logic [15:0] b);
    wr(A_CTRL, 16'h0000);
    wr(A_CTRL, 16'h0002);
    wr(A_DIV, {12'h000, k});
    wr(A_CMPA, a);
    wr(A_CMPB, b);
    wr(A_CTRL, c);
  endtask

  initial begin
    logic [15:0] d;
    int act, per, t0, t1, t2, t3, hits;
    rst_n = 1'b0; ext_run = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset read", int'(d), 0);
    end
    chk("R1 reset pin", int'(pwm_out), 0);
    chk("R1 reset irq", int'(irq), 0);

    // R2 readback and reserved bits
    wr(A_CMPA, 16'h1234); rd(A_CMPA, d); chk("R2 cmpA", int'(d), 'h1234);
    wr(A_CMPB, 16'hABCD); rd(A_CMPB, d); chk("R2 cmpB", int'(d), 'hABCD);
    wr(A_DIV, 16'hFFFF);  rd(A_DIV, d);  chk("R2 div", int'(d), 'h000F);
    wr(A_IEN, 16'hFFFF);  rd(A_IEN, d);  chk("R2 ien", int'(d), 'h0003);
    wr(A_CTRL, 16'hFFFF); rd(A_CTRL, d); chk("R2 R3 ctrl", int'(d), 'h017D);
    rd(3'd7, d); chk("R2 addr7", int'(d), 0);
    wr(A_CTRL, 16'h0000); wr(A_IEN, 16'h0000);

    // R4 R5 divider sweep: A=1 B=3 gives active 2 counts, period 4 counts
    for (int k = 0; k < 6; k++) begin
      cfg(16'h0005, 4'(k), 16'd1, 16'd3);
      meas(1'b0, act, per);
      chk("R5 active", act, 2 << k);
      chk("R4 R5 period", per, 4 << k);
    end

    // R7 idle level and inversion
    cfg(16'h0105, 4'd0, 16'd1, 16'd3);
    meas(1'b1, act, per); chk("R7 idle1 active", act, 2); chk("R7 idle1 period", per, 4);
    cfg(16'h0015, 4'd0, 16'd1, 16'd3);
    meas(1'b1, act, per); chk("R7 invert active", act, 2);
    cfg(16'h0115, 4'd0, 16'd1, 16'd3);
    meas(1'b0, act, per); chk("R7 idle1 invert active", act, 2);
    cfg(16'h0001, 4'd0, 16'd1, 16'd3);
    hits = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (pwm_out) hits++; end
    chk("R7 output disabled", hits, 0);
    cfg(16'h0005, 4'd0, 16'd3, 16'd3);
    hits = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out) hits++; end
    chk("R7 equal compares B wins", hits, 0);

    // R6 external clock, 8 system clocks per count
    ext_run = 1'b1;
    cfg(16'h000D, 4'd0, 16'd1, 16'd3);
    meas(1'b0, act, per); chk("R6 ext active", act, 16); chk("R6 ext period", per, 32);
    wr(A_CTRL, 16'h0000);
    ext_run = 1'b0;

    // R9 fine mode, divider 1/4: half count = 2 clocks
    cfg(16'h0045, 4'd2, 16'd5, 16'd13);
    meas(1'b0, act, per); chk("R9 fine odd/odd active", act, 16); chk("R9 fine period", per, 28);
    cfg(16'h0045, 4'd2, 16'd4, 16'd13);
    meas(1'b0, act, per); chk("R9 fine even/odd active", act, 18);
    cfg(16'h0045, 4'd2, 16'd5, 16'd12);
    meas(1'b0, act, per); chk("R9 fine odd/even active", act, 14);

    // R8 buffered compare: old B=5 holds for the first period, 20 after wrap
    wr(A_CTRL, 16'h0000); wr(A_CTRL, 16'h0002); wr(A_DIV, 16'h0000);
    wr(A_CMPA, 16'd2); wr(A_CMPB, 16'd5);
    wr(A_CTRL, 16'h0020);
    wr(A_CMPB, 16'd20);
    rd(A_CMPB, d); chk("R8 shadow readback", int'(d), 20);
    wr(A_CTRL, 16'h0025);
    wait_lvl(1'b1, t0); wait_lvl(1'b0, t1); wait_lvl(1'b1, t2); wait_lvl(1'b0, t3);
    chk("R8 old B active", t1 - t0, 3);
    chk("R8 old period", t2 - t0, 6);
    chk("R8 new B active", t3 - t2, 18);

    // R10 R11 flags and interrupt gating
    cfg(16'h0005, 4'd0, 16'd1, 16'd3);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 16'h0000);
    rd(A_FLAG, d); chk("R10 flags set unmasked", int'(d), 3);
    chk("R11 irq masked", int'(irq), 0);
    wr(A_IEN, 16'h0001); #1 chk("R11 irq A", int'(irq), 1);
    wr(A_FLAG, 16'h0001); rd(A_FLAG, d); chk("R10 clear A", int'(d), 2);
    chk("R11 irq after clear", int'(irq), 0);
    wr(A_IEN, 16'h0002); #1 chk("R11 irq B", int'(irq), 1);
    wr(A_FLAG, 16'h0002); rd(A_FLAG, d); chk("R10 clear B", int'(d), 0);
    wr(A_IEN, 16'h0000);

    // R3 clear strobe while active
    cfg(16'h0005, 4'd0, 16'd1, 16'd100);
    repeat (10) @(negedge clk);
    chk("R3 pin active before clear", int'(pwm_out), 1);
    wr(A_CTRL, 16'h0006);
    rd(A_CNT, d); chk("R3 count cleared", int'(d), 0);
    chk("R3 pin idle after clear", int'(pwm_out), 0);
    rd(A_CTRL, d); chk("R3 clear bit reads 0", int'(d), 'h0004);

    // R12 R4 counter load, hold, rollover past B
    wr(A_CNT, 16'h1234); rd(A_CNT, d); chk("R12 load", int'(d), 'h1234);
    repeat (10) @(negedge clk);
    rd(A_CNT, d); chk("R4 hold stopped", int'(d), 'h1234);
    wr(A_DIV, 16'h0003); wr(A_CMPB, 16'd3); wr(A_CNT, 16'hFFFE);
    wr(A_CTRL, 16'h0001);
    repeat (12) @(negedge clk);
    wr(A_CTRL, 16'h0000);
    rd(A_CNT, d); chk("R12 above B counts up", int'(d), 'hFFFF);
    wr(A_CTRL, 16'h0001);
    repeat (12) @(negedge clk);
    wr(A_CTRL, 16'h0000);
    rd(A_CNT, d); chk("R12 rollover", int'(d), 0);

    // R5 reserved code 15 divides by 16384
    cfg(16'h0001, 4'd15, 16'd1, 16'd200);
    repeat (40960) @(negedge clk);
    rd(A_CNT, d); chk("R5 code 15", int'(d), 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule